// File: doc/BRIEF.md
# ADC Over-Threshold Alarm Counter

This block watches the stream of 12-bit results coming out of an analog-to-digital converter. It raises a sticky alarm flag once a programmable number of those results have landed above a programmable threshold. A single 16-bit configuration word sets three things: the threshold, the number of trips required (one to eight), and whether the trips must come back to back or may be spread out with other results between them.

The comparison is unsigned when the converter runs in unipolar format and two's complement when it runs in bipolar format. A level input selects the format. Software clears the flag with a status-read strobe. That strobe also restarts the trip count, and any write to the configuration word does the same. Setting the threshold to the largest value the current format can represent makes the alarm impossible to trigger.

Top module: `adc_alarm_watch`

## Requirements
- R1: After reset the alarm output is 0 and the configuration holds mode 0, trip code 0 and threshold 0xFFF, so unipolar results never raise the alarm until the word is rewritten.
- R2: A result counts as a trip only when it is strictly greater than the threshold. A result equal to the threshold is not a trip.
- R3: The configuration word is laid out as bit 15 = mode, bits 14:12 = trip code, bits 11:0 = threshold. The alarm is raised on the clock edge that accepts trip number code+1, so code 0 needs 1 trip and code 7 needs 8.
- R4: With mode = 0, a non-trip result leaves the trip count unchanged, so trips accumulate across gaps.
- R5: With mode = 1, any result at or below the threshold returns the trip count to zero.
- R6: With bipolar = 0 the result and the threshold are compared as unsigned numbers. With bipolar = 1 both are compared as two's complement numbers.
- R7: A threshold of 0xFFF with bipolar = 0, or 0x7FF with bipolar = 1, is never exceeded, so the alarm never rises.
- R8: Once raised, the alarm stays at 1 until a status read or a configuration write. While the alarm is 1, results do not advance the trip count.
- R9: A status-read strobe clears the alarm and the trip count on the next edge. A result presented in the same cycle as the strobe is discarded.
- R10: A configuration write clears the alarm and the trip count on the next edge. It takes priority over a result presented in the same cycle, and that result is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word: mode, trip code, threshold |
| bipolar | input | 1 | 1 = two's complement results, 0 = unsigned |
| res_valid | input | 1 | Conversion result valid strobe |
| res_data | input | 12 | Conversion result |
| stat_rd | input | 1 | Status read strobe; clears the alarm |
| alarm | output | 1 | Sticky over-threshold alarm status |

## Verification
The hardest situations to reach are the ones where the counter is part-way to its target and something else arrives in the same cycle as a result: a clear strobe, a configuration write, or a non-trip in consecutive mode. A partial count cannot be seen directly at the ports. To expose it, the bench sweeps every combination of mode, trip code and polarity, feeds in an arithmetic stream of results with status reads interleaved at a fixed stride, and compares the alarm every cycle against a count model kept in the bench. Directed sequences then place writes and reads in the same cycle as trips, and a full 4096-value sweep confirms that the disabling thresholds are never exceeded.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
    localparam int DATA_W = 12;
    localparam int CODE_W = 3;
    localparam int CFG_W  = 1 + CODE_W + DATA_W;

    typedef struct packed {
        logic              consec;
        logic [CODE_W-1:0] code;
        logic [DATA_W-1:0] thr;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{consec: 1'b0, code: '0, thr: '1};
endpackage

// File: rtl/alarm_cfg_reg.sv
module alarm_cfg_reg
    import alarm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) cfg_d = cfg_t'(wdata);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= CFG_RESET;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/alarm_trip_cmp.sv
module alarm_trip_cmp #(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] thr,
    input  logic              bipolar,
    output logic              trip
);
    logic gt_uns, gt_sgn;

    always_comb begin
        gt_uns = data > thr;
        gt_sgn = $signed(data) > $signed(thr);
        trip   = bipolar ? gt_sgn : gt_uns;
    end
endmodule

// File: rtl/alarm_trip_ctr.sv
module alarm_trip_ctr #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              valid,
    input  logic              trip,
    input  logic              consec,
    input  logic [CODE_W-1:0] code,
    output logic              alarm
);
    localparam int CNT_W = CODE_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             alarm;
    } ctr_t;

    ctr_t             st_d, st_q;
    logic [CNT_W-1:0] need, inc;

    always_comb begin
        need = {1'b0, code} + CNT_W'(1);
        inc  = st_q.cnt + CNT_W'(1);
        st_d = st_q;
        if (clr) begin
            st_d.cnt   = '0;
            st_d.alarm = 1'b0;
        end else if (valid && !st_q.alarm) begin
            if (trip) begin
                if (inc >= need) begin
                    st_d.cnt   = need;
                    st_d.alarm = 1'b1;
                end else begin
                    st_d.cnt = inc;
                end
            end else if (consec) begin
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign alarm = st_q.alarm;
endmodule

// File: rtl/adc_alarm_watch.sv
module adc_alarm_watch
    import alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              bipolar,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic              stat_rd,
    output logic              alarm
);
    cfg_t cfg;
    logic trip;
    logic clr;

    assign clr = cfg_we | stat_rd;

    alarm_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    alarm_trip_cmp #(.DATA_W(DATA_W)) u_cmp (
        .data    (res_data),
        .thr     (cfg.thr),
        .bipolar (bipolar),
        .trip    (trip)
    );

    alarm_trip_ctr #(.CODE_W(CODE_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .valid  (res_valid),
        .trip   (trip),
        .consec (cfg.consec),
        .code   (cfg.code),
        .alarm  (alarm)
    );
endmodule

// File: rtl/alarm_watch_chk.sv
module alarm_watch_chk
    import alarm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [CFG_W-1:0]  cfg_wdata,
    input logic              bipolar,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_data,
    input logic              stat_rd,
    input logic              alarm
);
    logic [CFG_W-1:0] shadow;
    logic             disabled, one_trip_gt;

    always_ff @(posedge clk) begin
        if (!rst_n)      shadow <= {1'b0, {CODE_W{1'b0}}, {DATA_W{1'b1}}};
        else if (cfg_we) shadow <= cfg_wdata;
    end

    always_comb begin
        disabled = (!bipolar && shadow[DATA_W-1:0] == {DATA_W{1'b1}}) ||
                   ( bipolar && shadow[DATA_W-1:0] == {1'b0, {(DATA_W-1){1'b1}}});
        one_trip_gt = (shadow[DATA_W+CODE_W-1:DATA_W] == '0) && !bipolar &&
                      (res_data > shadow[DATA_W-1:0]);
    end

    // R9
    rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> !alarm);

    // R10
    wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !alarm);

    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm && !cfg_we && !stat_rd) |=> alarm);

    // R3
    no_rise_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm && !res_valid) |=> !alarm);

    // R7
    disabled_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm && disabled) |=> !alarm);

    // R2
    single_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !cfg_we && !stat_rd && one_trip_gt) |=> alarm);
endmodule

bind adc_alarm_watch alarm_watch_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .bipolar   (bipolar),
    .res_valid (res_valid),
    .res_data  (res_data),
    .stat_rd   (stat_rd),
    .alarm     (alarm)
);

// File: tb/sim_adc_alarm_watch.sv
module sim_adc_alarm_watch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        bipolar = 1'b0;
    logic        res_valid = 1'b0;
    logic [11:0] res_data = '0;
    logic        stat_rd = 1'b0;
    logic        alarm;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc_cnt = 0;
    string tag = "R1";

    logic [15:0] m_cfg = 16'h0FFF;
    int          m_cnt = 0;
    logic        m_alarm = 1'b0;

    always #2 clk = ~clk;

    adc_alarm_watch u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .bipolar(bipolar), .res_valid(res_valid), .res_data(res_data),
        .stat_rd(stat_rd), .alarm(alarm)
    );

    always @(posedge clk) begin
        cyc_cnt <= cyc_cnt + 1;
        if (cyc_cnt > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc_cnt);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    function automatic bit is_trip(logic [11:0] d, logic [11:0] t, logic b);
        if (b) return int'($signed(d)) > int'($signed(t));
        return int'(d) > int'(t);
    endfunction

    task automatic check(string what, logic act, logic exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: alarm actual %0b expected %0b", what, act, exp);
        end
    endtask

    task automatic cyc(logic we, logic [15:0] wd, logic v, logic [11:0] d, logic rd);
        cfg_we = we; cfg_wdata = wd; res_valid = v; res_data = d; stat_rd = rd;
        @(posedge clk);
        if (we || rd) begin
            m_cnt = 0; m_alarm = 1'b0;
            if (we) m_cfg = wd;
        end else if (v && !m_alarm) begin
            if (is_trip(d, m_cfg[11:0], bipolar)) begin
                m_cnt = m_cnt + 1;
                if (m_cnt >= int'(m_cfg[14:12]) + 1) m_alarm = 1'b1;
            end else if (m_cfg[15]) begin
                m_cnt = 0;
            end
        end
        @(negedge clk);
        cfg_we = 1'b0; res_valid = 1'b0; stat_rd = 1'b0;
        check(tag, alarm, m_alarm);
    endtask

    task automatic wr(logic mode, logic [2:0] code, logic [11:0] thr);
        cyc(1'b1, {mode, code, thr}, 1'b0, 12'h0, 1'b0);
    endtask

    task automatic res(logic [11:0] d);
        cyc(1'b0, 16'h0, 1'b1, d, 1'b0);
    endtask

    task automatic rd();
        cyc(1'b0, 16'h0, 1'b0, 12'h0, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset", alarm, 1'b0);

        // R1 / R7: default threshold never exceeded, unipolar full sweep
        tag = "R1 default thr";
        for (int i = 0; i < 4096; i++) res(12'(i));
        // R7: bipolar disable value full sweep
        tag = "R7 bipolar disable";
        bipolar = 1'b1;
        wr(1'b0, 3'd0, 12'h7FF);
        for (int i = 0; i < 4096; i++) res(12'(i));
        bipolar = 1'b0;

        // R2: equality is not a trip
        tag = "R2 strict greater";
        wr(1'b0, 3'd0, 12'h123);
        res(12'h123);
        res(12'h124);
        check("R2 just above", alarm, 1'b1);

        // R3 R4 R5 R6: full sweep of mode, code, polarity
        for (int b = 0; b < 2; b++)
            for (int m = 0; m < 2; m++)
                for (int c = 0; c < 8; c++) begin
                    bipolar = b[0];
                    tag = m ? "R5 R3 R6 sweep" : "R4 R3 R6 sweep";
                    wr(m[0], 3'(c), b ? 12'h000 : 12'h800);
                    for (int i = 0; i < 48; i++) begin
                        if (i % 13 == 12) rd();
                        else res(12'((i * 1237 + m * 77 + c * 311) & 32'hFFF));
                    end
                end

        // R6: same code, differing polarity
        tag = "R6 polarity";
        bipolar = 1'b1;
        wr(1'b0, 3'd0, 12'h000);
        res(12'h800);
        check("R6 negative in bipolar", alarm, 1'b0);
        bipolar = 1'b0;
        res(12'h800);
        check("R6 large in unipolar", alarm, 1'b1);

        // R4: cumulative across gaps
        tag = "R4 cumulative";
        wr(1'b0, 3'd2, 12'h100);
        res(12'h200); res(12'h050); res(12'h300); res(12'h000);
        check("R4 two trips", alarm, 1'b0);
        res(12'h101);
        check("R4 third trip", alarm, 1'b1);

        // R5: consecutive restart
        tag = "R5 consecutive";
        wr(1'b1, 3'd2, 12'h100);
        res(12'h200); res(12'h200); res(12'h100);
        res(12'h200); res(12'h200);
        check("R5 broken run", alarm, 1'b0);
        res(12'h200);
        check("R5 full run", alarm, 1'b1);

        // R8: sticky, frozen while set
        tag = "R8 sticky";
        res(12'h000); res(12'h000);
        check("R8 held", alarm, 1'b1);

        // R9: read clears and restarts; read with result discards it
        tag = "R9 read clear";
        wr(1'b0, 3'd1, 12'h010);
        res(12'h020);
        cyc(1'b0, 16'h0, 1'b1, 12'h020, 1'b1);
        check("R9 read plus result", alarm, 1'b0);
        res(12'h020);
        check("R9 count restarted", alarm, 1'b0);
        res(12'h020);
        check("R9 second trip after read", alarm, 1'b1);
        rd();
        check("R9 cleared", alarm, 1'b0);

        // R10: write priority over a same-cycle trip
        tag = "R10 write priority";
        wr(1'b0, 3'd0, 12'h010);
        cyc(1'b1, 16'h0010, 1'b1, 12'hFF0, 1'b0);
        check("R10 result dropped", alarm, 1'b0);
        res(12'hFF0);
        check("R10 trip after write", alarm, 1'b1);
        wr(1'b0, 3'd0, 12'h010);
        check("R10 write clears", alarm, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule